// File: doc/BRIEF.md
# Serialized Mailbox Command Sequencer

This engine sits on the host side of a doorbell mailbox and pushes commands to a service processor one at a time. Requesters drop command descriptors into a small input queue. A descriptor holds the command class, the command code, 16 control flags and three 64-bit arguments. When a descriptor is accepted, the engine gives it a sequence number. It then builds the four command words and rings the mailbox doorbell. After that it follows the doorbell bits that the far side raises in the host doorbell register.

Each command finishes with one completion record. The record carries a kind (done, timeout or error), the sequence number and four words. For a command that asks for a response, the four words are the response words. The primary status sits in the top 16 bits of word 0. The engine clears every doorbell bit it observes and re-sends the in-flight command when the far side announces that it has been reset. It also pauses issuing after a run of failed sends.

Top module: `mbox_cmd_sequencer`

## Requirements
- R1: At most one command is in flight. `mb_ring` is not raised again until the current command has completed on `cpl_valid`, or has been re-sent after a reset notification.
- R2: Command word 0 carries zero in bits 63:48, the control flags ORed with 0x0200 (ack request) in bits 47:32, the sequence number in bits 31:16, the class in bits 15:8 and the code in bits 7:0. Words 1 to 3 carry the three arguments.
- R3: Sequence numbers are given in acceptance order. They start at 1, go up by one per accepted descriptor and return to 1 after the value SEQ_MAX (0xFFFE by default). They are never 0.
- R4: Doorbell bit positions are ack = bit 0, response = bit 1 and reset = bit 2. A command whose flags lack 0x0100 (response request) completes as done (kind 0) on the ack bit, with all four completion words zero.
- R5: A command with flag 0x0100 completes as done only on the response bit. This holds whether the ack comes first or both bits come in the same cycle. The completion words copy `rsp_word0..3`.
- R6: If bits 31:16 of `rsp_word0` differ from the sent sequence number, completion word 0 has 0x0003 in bits 63:48 and keeps the rest of the response.
- R7: Every cycle in which `hdb_bits` is nonzero is followed, one cycle later, by an `hdb_clr` pulse. It comes with `hdb_and_val` = 3'b111 & ~observed bits.
- R8: The reset bit wins over ack and response bits in the same cycle. No completion is produced, and the same four words, with the same sequence number, are rung again.
- R9: If the doorbell stays quiet, a timeout completion (kind 1) appears `tmo_cycles`+1 cycles after the ring cycle. Its word 0 is 0x00FE in bits 63:48 and zero elsewhere.
- R10: `mb_fail` high during a ring cycle gives an error completion (kind 2) in the next cycle, with word 0 = 0x00FE in bits 63:48.
- R11: The fourth consecutive failed send pauses issuing. A pulse on `resume_issue` restarts it and clears the failure count, as does any successful send.
- R12: `cmd_ready` is low while the input queue (FIFO_DEPTH entries) is full. Queued descriptors issue in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Input queue has space |
| cmd_flags | input | 16 | Control flags (0x0100 = response wanted) |
| cmd_class | input | 8 | Command class |
| cmd_code | input | 8 | Command code |
| cmd_arg1 | input | 64 | Argument word 1 |
| cmd_arg2 | input | 64 | Argument word 2 |
| cmd_arg3 | input | 64 | Argument word 3 |
| tmo_cycles | input | TMO_W | Timeout length in cycles |
| resume_issue | input | 1 | Leave the paused state |
| mb_ring | output | 1 | Doorbell pulse; command words valid |
| mb_word0 | output | 64 | Command word 0 |
| mb_word1 | output | 64 | Command word 1 |
| mb_word2 | output | 64 | Command word 2 |
| mb_word3 | output | 64 | Command word 3 |
| mb_fail | input | 1 | Send failed (sampled in ring cycle) |
| hdb_bits | input | 3 | Host doorbell: ack, response, reset |
| rsp_word0 | input | 64 | Response word 0 |
| rsp_word1 | input | 64 | Response word 1 |
| rsp_word2 | input | 64 | Response word 2 |
| rsp_word3 | input | 64 | Response word 3 |
| hdb_clr | output | 1 | AND-write strobe to host doorbell |
| hdb_and_val | output | 3 | AND-write value |
| cpl_valid | output | 1 | Completion pulse |
| cpl_kind | output | 2 | 0 done, 1 timeout, 2 error |
| cpl_seq | output | 16 | Sequence number of completed command |
| cpl_word0 | output | 64 | Completion word 0 |
| cpl_word1 | output | 64 | Completion word 1 |
| cpl_word2 | output | 64 | Completion word 2 |
| cpl_word3 | output | 64 | Completion word 3 |

## Verification
Some properties can be checked on every cycle. These are: single occupancy of the mailbox, the forced ack flag and the legal sequence range on each ring, the clear value against the bits seen one cycle earlier, the 0x00FE code on every timeout or error record, and the absence of a completion after a reset notice. Other behaviour only shows up in the bench's scenarios. This covers the ordering of ack before response, the replacement of the status on a sequence mismatch, the exact timeout cycle, the pause after the fourth failure and its release, the wrap of the sequence numbers, and the queue order under back-pressure.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;
  localparam int WORD_W = 64;
  localparam int SEQ_W  = 16;
  localparam int DB_W   = 3;
  localparam int DB_ACK = 0;
  localparam int DB_RSP = 1;
  localparam int DB_RST = 2;

  localparam logic [15:0] FLG_ACK     = 16'h0200;
  localparam logic [15:0] FLG_RSP     = 16'h0100;
  localparam logic [15:0] PRI_SEQ_ERR = 16'h0003;
  localparam logic [15:0] PRI_GENERIC = 16'h00FE;

  typedef enum logic [1:0] {MB_IDLE, MB_SENT, MB_WRESP} mb_state_e;
  typedef enum logic [1:0] {CK_DONE = 2'd0, CK_TMO = 2'd1, CK_ERR = 2'd2} cpl_kind_e;

  // header word: ack request is always forced on
  function automatic logic [WORD_W-1:0] pack_head(logic [15:0] flags, logic [SEQ_W-1:0] seq,
                                                  logic [7:0] cls, logic [7:0] code);
    return {16'h0000, flags | FLG_ACK, seq, cls, code};
  endfunction

  function automatic logic [SEQ_W-1:0] seq_after(logic [SEQ_W-1:0] s, logic [SEQ_W-1:0] top);
    return (s >= top) ? SEQ_W'(1) : s + SEQ_W'(1);
  endfunction

  function automatic logic [DB_W-1:0] clear_mask(logic [DB_W-1:0] seen);
    return {DB_W{1'b1}} & ~seen;
  endfunction

  function automatic logic [WORD_W-1:0] with_primary(logic [WORD_W-1:0] w, logic [15:0] pri);
    return {pri, w[47:0]};
  endfunction
endpackage

// File: rtl/mbseq_fifo.sv
module mbseq_fifo #(
  parameter int W     = 256,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [CW-1:0] fill;

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign head  = mem[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else begin
      if (push) begin
        mem[wr_p] <= din;
        wr_p <= (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + AW'(1);
      end
      if (pop)
        rd_p <= (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + AW'(1);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/mbseq_timer.sv
module mbseq_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mbox_cmd_sequencer.sv
module mbox_cmd_sequencer
  import mbseq_pkg::*;
#(
  parameter int              FIFO_DEPTH = 4,
  parameter int              TMO_W      = 20,
  parameter logic [15:0]     SEQ_MAX    = 16'hFFFE,
  parameter int              FAIL_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_flags,
  input  logic [7:0]        cmd_class,
  input  logic [7:0]        cmd_code,
  input  logic [63:0]       cmd_arg1,
  input  logic [63:0]       cmd_arg2,
  input  logic [63:0]       cmd_arg3,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic              resume_issue,
  output logic              mb_ring,
  output logic [63:0]       mb_word0,
  output logic [63:0]       mb_word1,
  output logic [63:0]       mb_word2,
  output logic [63:0]       mb_word3,
  input  logic              mb_fail,
  input  logic [2:0]        hdb_bits,
  input  logic [63:0]       rsp_word0,
  input  logic [63:0]       rsp_word1,
  input  logic [63:0]       rsp_word2,
  input  logic [63:0]       rsp_word3,
  output logic              hdb_clr,
  output logic [2:0]        hdb_and_val,
  output logic              cpl_valid,
  output logic [1:0]        cpl_kind,
  output logic [15:0]       cpl_seq,
  output logic [63:0]       cpl_word0,
  output logic [63:0]       cpl_word1,
  output logic [63:0]       cpl_word2,
  output logic [63:0]       cpl_word3
);
  localparam int ENT_W = 4 * WORD_W;
  localparam int FCW   = $clog2(FAIL_LIMIT + 2);

  mb_state_e           state;
  logic [SEQ_W-1:0]    seq_ctr;
  logic                resend_q, paused_q;
  logic [FCW-1:0]      fail_cnt;

  // queue side
  logic                q_push, q_pop, q_full, q_empty;
  logic [ENT_W-1:0]    q_din, q_head;

  assign cmd_ready = !q_full;
  assign q_push    = cmd_valid && cmd_ready;
  assign q_din     = {cmd_arg3, cmd_arg2, cmd_arg1,
                      pack_head(cmd_flags, seq_ctr, cmd_class, cmd_code)};

  mbseq_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
    .head(q_head), .full(q_full), .empty(q_empty));

  // named events
  logic busy, need_rsp, issue_go, send_bad, live;
  logic ev_reset, ev_ack, ev_rsp, ev_tmo, ack_done, finish, tmo_zero;
  logic seq_bad;

  assign busy     = (state != MB_IDLE);
  assign need_rsp = mb_word0[32 + 8];
  assign issue_go = (state == MB_IDLE) && (resend_q || (!q_empty && !paused_q));
  assign q_pop    = issue_go && !resend_q;
  assign send_bad = (state == MB_SENT) && mb_ring && mb_fail;
  assign live     = busy && !send_bad;
  assign ev_reset = live && hdb_bits[DB_RST];
  assign ev_ack   = live && !hdb_bits[DB_RST] && hdb_bits[DB_ACK] && (state == MB_SENT);
  assign ev_rsp   = live && !hdb_bits[DB_RST] && hdb_bits[DB_RSP] && need_rsp;
  assign ev_tmo   = live && (hdb_bits == '0) && tmo_zero;
  assign ack_done = ev_ack && !need_rsp;
  assign finish   = ack_done || ev_rsp || ev_tmo || send_bad;
  assign seq_bad  = (rsp_word0[31:16] != mb_word0[31:16]);

  mbseq_timer #(.W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(issue_go), .load_val(tmo_cycles),
    .run(busy && (hdb_bits == '0)), .zero(tmo_zero));

  // completion record
  logic [WORD_W-1:0] fin_w0, fin_w1, fin_w2, fin_w3;
  cpl_kind_e         fin_kind;

  always_comb begin
    fin_kind = CK_DONE;
    fin_w0 = '0; fin_w1 = '0; fin_w2 = '0; fin_w3 = '0;
    if (send_bad || ev_tmo) begin
      fin_kind = send_bad ? CK_ERR : CK_TMO;
      fin_w0   = with_primary('0, PRI_GENERIC);
    end else if (ev_rsp) begin
      fin_w0 = seq_bad ? with_primary(rsp_word0, PRI_SEQ_ERR) : rsp_word0;
      fin_w1 = rsp_word1;
      fin_w2 = rsp_word2;
      fin_w3 = rsp_word3;
    end
  end

  logic [FCW-1:0] fail_next;
  assign fail_next = fail_cnt + FCW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= MB_IDLE;
      seq_ctr   <= SEQ_W'(1);
      resend_q  <= 1'b0;
      paused_q  <= 1'b0;
      fail_cnt  <= '0;
      mb_ring   <= 1'b0;
      mb_word0  <= '0; mb_word1 <= '0; mb_word2 <= '0; mb_word3 <= '0;
      hdb_clr   <= 1'b0;
      hdb_and_val <= '0;
      cpl_valid <= 1'b0;
      cpl_kind  <= 2'd0;
      cpl_seq   <= '0;
      cpl_word0 <= '0; cpl_word1 <= '0; cpl_word2 <= '0; cpl_word3 <= '0;
    end else begin
      if (q_push) seq_ctr <= seq_after(seq_ctr, SEQ_MAX);

      mb_ring     <= issue_go;
      hdb_clr     <= (hdb_bits != '0);
      hdb_and_val <= clear_mask(hdb_bits);
      cpl_valid   <= finish;
      if (finish) begin
        cpl_kind  <= fin_kind;
        cpl_seq   <= mb_word0[31:16];
        cpl_word0 <= fin_w0; cpl_word1 <= fin_w1;
        cpl_word2 <= fin_w2; cpl_word3 <= fin_w3;
      end

      if (issue_go) begin
        state    <= MB_SENT;
        resend_q <= 1'b0;
        if (!resend_q) begin
          mb_word0 <= q_head[0 +: 64];
          mb_word1 <= q_head[64 +: 64];
          mb_word2 <= q_head[128 +: 64];
          mb_word3 <= q_head[192 +: 64];
        end
      end else if (finish) begin
        state <= MB_IDLE;
      end else if (ev_reset) begin
        state    <= MB_IDLE;
        resend_q <= 1'b1;
      end else if (ev_ack) begin
        state <= MB_WRESP;
      end

      if (resume_issue) begin
        paused_q <= 1'b0;
        fail_cnt <= '0;
      end
      if (send_bad) begin
        fail_cnt <= fail_next;
        if (int'(fail_next) > FAIL_LIMIT) paused_q <= 1'b1;
      end else if (state == MB_SENT && mb_ring) begin
        fail_cnt <= '0;
      end
    end
  end

  // checker state: command in flight between a ring and its retirement
  logic flight_q;
  always_ff @(posedge clk) begin
    if (!rst_n) flight_q <= 1'b0;
    else        flight_q <= (flight_q || mb_ring) && !(cpl_valid || ev_reset);
  end

  p_single_r1: assert property (@(posedge clk) disable iff (!rst_n) mb_ring |-> !flight_q);
  p_ack_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_ring |-> (mb_word0[41] && mb_word0[63:48] == 16'h0000));
  p_seq_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_ring |-> (mb_word0[31:16] != 16'h0000 && mb_word0[31:16] <= SEQ_MAX));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdb_clr |-> ((hdb_and_val | $past(hdb_bits)) == 3'b111 && (hdb_and_val & $past(hdb_bits)) == 3'b000));
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n) ev_reset |=> !cpl_valid);
  p_fail_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_kind != 2'd0) |-> cpl_word0 == {16'h00FE, 48'h0});
endmodule

// File: tb/sim_mbox_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_mbox_cmd_sequencer;
  localparam logic [15:0] SEQ_TOP = 16'd6;
  localparam int TW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready;
  logic [15:0] cmd_flags = 0;
  logic [7:0]  cmd_class = 0, cmd_code = 0;
  logic [63:0] cmd_arg1 = 0, cmd_arg2 = 0, cmd_arg3 = 0;
  logic [TW-1:0] tmo_cycles = 20'd1000;
  logic resume_issue = 0, mb_ring, mb_fail = 0;
  logic [63:0] mb_word0, mb_word1, mb_word2, mb_word3;
  logic [2:0]  hdb_bits = 0;
  logic [63:0] rsp_word0 = 0, rsp_word1 = 0, rsp_word2 = 0, rsp_word3 = 0;
  logic hdb_clr, cpl_valid;
  logic [2:0] hdb_and_val;
  logic [1:0] cpl_kind;
  logic [15:0] cpl_seq;
  logic [63:0] cpl_word0, cpl_word1, cpl_word2, cpl_word3;

  always #5 clk = ~clk;

  mbox_cmd_sequencer #(.FIFO_DEPTH(4), .TMO_W(TW), .SEQ_MAX(SEQ_TOP), .FAIL_LIMIT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_flags(cmd_flags), .cmd_class(cmd_class), .cmd_code(cmd_code),
    .cmd_arg1(cmd_arg1), .cmd_arg2(cmd_arg2), .cmd_arg3(cmd_arg3),
    .tmo_cycles(tmo_cycles), .resume_issue(resume_issue),
    .mb_ring(mb_ring), .mb_word0(mb_word0), .mb_word1(mb_word1),
    .mb_word2(mb_word2), .mb_word3(mb_word3), .mb_fail(mb_fail),
    .hdb_bits(hdb_bits), .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
    .rsp_word2(rsp_word2), .rsp_word3(rsp_word3),
    .hdb_clr(hdb_clr), .hdb_and_val(hdb_and_val),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_seq(cpl_seq),
    .cpl_word0(cpl_word0), .cpl_word1(cpl_word1),
    .cpl_word2(cpl_word2), .cpl_word3(cpl_word3));

  int n_total = 0, n_bad = 0, n_wraps = 0;
  logic [15:0] exp_seq = 16'd1;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] head_of(input logic [15:0] fl, input logic [15:0] sq,
                                          input logic [7:0] cl, input logic [7:0] cd);
    logic [63:0] w;
    w = 64'(cd) | (64'(cl) << 8) | (64'(sq) << 16) | (64'(fl | 16'h0200) << 32);
    return w;
  endfunction

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  task automatic push(input logic [15:0] fl, input logic [7:0] cl, input logic [7:0] cd,
                      input logic [63:0] a1, a2, a3, output logic [63:0] w0);
    @(negedge clk);
    cmd_valid = 1; cmd_flags = fl; cmd_class = cl; cmd_code = cd;
    cmd_arg1 = a1; cmd_arg2 = a2; cmd_arg3 = a3;
    while (!cmd_ready) @(negedge clk);
    w0 = head_of(fl, exp_seq, cl, cd);
    if (exp_seq == SEQ_TOP) begin exp_seq = 16'd1; n_wraps++; end
    else exp_seq = exp_seq + 16'd1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_issue(input string req, input logic [63:0] w0, a1, a2, a3);
    bit seen = 0;
    for (int k = 0; k < 100 && !seen; k++) begin
      @(negedge clk);
      if (mb_ring) seen = 1;
    end
    chk({req, " ring"}, 64'(seen), 64'd1);
    chk({req, " word0"}, mb_word0, w0);
    chk({req, " words1-3"}, mb_word1 ^ mb_word2 ^ mb_word3, a1 ^ a2 ^ a3);
    chk({req, " word3"}, mb_word3, a3);
  endtask

  logic [63:0] w0, a1, a2, a3, rw0;
  logic [63:0] fw0 [5];
  logic [63:0] fa [5];

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 ready after reset", 64'(cmd_ready), 64'd1);
    chk("R1 no ring after reset", 64'(mb_ring), 64'd0);
    chk("R4 no completion after reset", 64'(cpl_valid), 64'd0);
    chk("R7 no clear after reset", 64'(hdb_clr), 64'd0);

    // random mix of response styles
    for (int i = 0; i < 40; i++) begin
      logic [15:0] fl;
      logic [7:0] cl, cd;
      int mode;
      bit want;
      want = $urandom_range(0, 1) != 0;
      fl = 16'($urandom) & ~16'h0100;
      if (want) fl = fl | 16'h0100;
      cl = 8'($urandom); cd = 8'($urandom);
      a1 = r64(); a2 = r64(); a3 = r64();
      push(fl, cl, cd, a1, a2, a3, w0);
      expect_issue("R2 R3 random", w0, a1, a2, a3);
      mode = $urandom_range(0, 2);
      if (!want) begin
        hdb_bits = 3'b001;
        @(negedge clk); hdb_bits = 0;
        chk("R4 ack completes", 64'(cpl_valid), 64'd1);
        chk("R4 kind done", 64'(cpl_kind), 64'd0);
        chk("R4 zero words", cpl_word0 | cpl_word3, 64'd0);
        chk("R7 clear value ack", 64'(hdb_and_val), 64'(3'b110));
      end else begin
        rsp_word1 = r64(); rsp_word2 = r64(); rsp_word3 = r64();
        rw0 = {16'($urandom), 16'($urandom), w0[31:16], 16'($urandom)};
        if (mode == 2) rw0[31:16] = rw0[31:16] ^ 16'h0100;
        rsp_word0 = rw0;
        if (mode == 0) begin
          hdb_bits = 3'b001;
          @(negedge clk);
          chk("R5 ack alone does not finish", 64'(cpl_valid), 64'd0);
          hdb_bits = 3'b010;
        end else begin
          hdb_bits = 3'b011;
        end
        @(negedge clk); hdb_bits = 0;
        chk("R5 response completes", 64'(cpl_valid), 64'd1);
        chk("R5 seq tag", 64'(cpl_seq), 64'(w0[31:16]));
        chk("R5 word3", cpl_word3, rsp_word3);
        if (mode == 2) chk("R6 seq mismatch status", cpl_word0, {16'h0003, rw0[47:0]});
        else           chk("R5 word0", cpl_word0, rw0);
        chk("R7 clear value rsp", 64'(hdb_and_val), (mode == 0) ? 64'(3'b101) : 64'(3'b100));
      end
    end
    chk("R3 sequence wrapped", 64'(n_wraps > 0), 64'd1);

    // timeout
    tmo_cycles = 20'd5;
    a1 = r64(); a2 = r64(); a3 = r64();
    push(16'h0100, 8'h11, 8'h22, a1, a2, a3, w0);
    expect_issue("R9 issue", w0, a1, a2, a3);
    repeat (5) @(negedge clk);
    chk("R9 not early", 64'(cpl_valid), 64'd0);
    @(negedge clk);
    chk("R9 timeout fires", 64'(cpl_valid), 64'd1);
    chk("R9 kind", 64'(cpl_kind), 64'd1);
    chk("R9 word0", cpl_word0, {16'h00FE, 48'h0});
    tmo_cycles = 20'd1000;

    // reset notification with ack in the same cycle
    a1 = r64(); a2 = r64(); a3 = r64();
    push(16'h0000, 8'h33, 8'h44, a1, a2, a3, w0);
    expect_issue("R8 first send", w0, a1, a2, a3);
    hdb_bits = 3'b101;
    @(negedge clk); hdb_bits = 0;
    chk("R8 no completion", 64'(cpl_valid), 64'd0);
    chk("R7 clear value reset", 64'(hdb_and_val), 64'(3'b010));
    expect_issue("R8 resend same words", w0, a1, a2, a3);
    hdb_bits = 3'b001;
    @(negedge clk); hdb_bits = 0;
    chk("R8 done after resend", 64'(cpl_valid), 64'd1);

    // failures and pause
    mb_fail = 1;
    for (int j = 0; j < 4; j++) begin
      a1 = r64(); a2 = r64(); a3 = r64();
      push(16'h0100, 8'(j), 8'h55, a1, a2, a3, w0);
      expect_issue("R10 failing send", w0, a1, a2, a3);
      @(negedge clk);
      chk("R10 error completion", 64'(cpl_valid), 64'd1);
      chk("R10 kind", 64'(cpl_kind), 64'd2);
      chk("R10 word0", cpl_word0, {16'h00FE, 48'h0});
    end
    mb_fail = 0;
    a1 = r64(); a2 = r64(); a3 = r64();
    push(16'h0000, 8'h66, 8'h77, a1, a2, a3, w0);
    begin
      bit rang = 0;
      repeat (20) begin @(negedge clk); if (mb_ring) rang = 1; end
      chk("R11 paused after four failures", 64'(rang), 64'd0);
    end
    resume_issue = 1;
    @(negedge clk); resume_issue = 0;
    expect_issue("R11 resumed", w0, a1, a2, a3);
    hdb_bits = 3'b001;
    @(negedge clk); hdb_bits = 0;
    chk("R11 resumed completes", 64'(cpl_valid), 64'd1);

    // back-pressure and order
    for (int j = 0; j < 5; j++) begin
      fa[j] = r64();
      push(16'h0000, 8'(8'hA0 + j), 8'h01, fa[j], 64'd0, 64'd0, fw0[j]);
      if (j == 0) expect_issue("R1 head issue", fw0[0], fa[0], 64'd0, 64'd0);
    end
    @(negedge clk);
    cmd_valid = 1; cmd_class = 8'hEE;
    @(negedge clk);
    chk("R12 full blocks", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    chk("R12 still full", 64'(cmd_ready), 64'd0);
    cmd_valid = 0;
    chk("R1 no second ring while busy", 64'(mb_ring), 64'd0);
    hdb_bits = 3'b001;
    @(negedge clk); hdb_bits = 0;
    chk("R1 head done", 64'(cpl_valid), 64'd1);
    for (int j = 1; j < 5; j++) begin
      expect_issue("R12 order", fw0[j], fa[j], 64'd0, 64'd0);
      hdb_bits = 3'b001;
      @(negedge clk); hdb_bits = 0;
      chk("R12 drained done", 64'(cpl_seq), 64'(fw0[j][31:16]));
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule